// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Unit

This unit holds the interrupt-reason, status and sequence-step registers of a small SCSI host controller and drives its single level-sensitive interrupt line. The controller core signals internal events with one-cycle strobes: command complete (with a status byte), DMA done, bus reset, selection enable and selection disable, and a soft reset. Each event updates the registers and may raise the interrupt. A CPU uses a byte-wide register port to read the registers and to write the configuration register.

Reading the interrupt-reason register is the acknowledge. The read returns the current reason and, at the same clock edge, clears the reason, clears terminal count, loads the sequence step with the "command done" code and lowers the interrupt. A command completion that arrives while an interrupt is still pending is not lost. The unit stores its status byte and posts it at the edge of the next acknowledge.

Register addresses: 0 status, 1 interrupt reason, 2 sequence step (3 bits, read zero-extended), 3 configuration, 4 last completion status byte. Only address 3 is writable. Status bits: bit 7 interrupt pending, bit 4 terminal count, bits 2:0 bus phase. Reason codes: 0x80 bus reset, 0x10 bus service. Configuration bit 6 suppresses the interrupt for a bus reset.

Top module: `scsi_int_status`

## Requirements
- R1: After reset, status, reason and sequence step read 0, `irq` is low, and configuration (address 3) reads 0x07.
- R2: A read at address 1 returns the current reason in the same cycle. At that clock edge the reason becomes 0, status bit 4 and bit 7 clear, the sequence step becomes 4 and `irq` falls.
- R3: A command completion while `irq` is low sets status to 0x93 (interrupt, terminal count, phase 3), reason to 0x10 and sequence step to 0. It raises `irq` and stores the status byte, which reads back at address 4.
- R4: A command completion while `irq` is high leaves status, reason, sequence step and address 4 unchanged. It is held, and it is posted as in R3 with the held byte at the edge of the next read of address 1.
- R5: When an acknowledge read and an event occur in the same cycle, the acknowledge is applied first and the event afterwards, so the event's effect is kept.
- R6: A bus reset event sets the reason to 0x80. It raises `irq` only when configuration bit 6 is 0.
- R7: A selection-disable event sets the reason to 0 and raises `irq`. A selection-enable event sets the reason to 0 and leaves `irq` as it was.
- R8: A DMA-done event sets status bit 4 and keeps the other status bits. It sets the reason to 0x10 and the sequence step to 0, and raises `irq`.
- R9: A soft-reset event returns every register to its R1 value, lowers `irq` and discards any held completion.
- R10: Writes to addresses other than 3 have no effect; a write to address 3 loads the configuration byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| ev_soft_rst | input | 1 | Soft reset event |
| ev_cmd_done | input | 1 | Command completion event |
| ev_cmd_status | input | 8 | Status byte that comes with the completion |
| ev_dma_done | input | 1 | DMA done event |
| ev_bus_reset | input | 1 | SCSI bus reset event |
| ev_sel_off | input | 1 | Selection disable event |
| ev_sel_on | input | 1 | Selection enable event |
| irq | output | 1 | Level-sensitive interrupt line |
| stat_o | output | 8 | Status register |
| reason_o | output | 8 | Interrupt-reason register |
| seq_o | output | 3 | Sequence-step register |

## Verification
Read data is combinational, so `reg_rdata` is checked in the same cycle as the read strobe. It carries the value from before the read's side effects. Every register and `irq` change appears one clock after the strobe that causes it. A held completion therefore shows up one clock after the acknowledge that releases it. The driver applies stimulus just after a rising edge and queues each expectation with a due cycle of zero or one. The monitor compares only at the falling edge of that cycle, when the inputs and the registered outputs are both settled.

// File: rtl/scsi_int_status.sv
module scsi_int_status #(
  parameter int              AW        = 3,
  parameter logic [AW-1:0]   A_STAT    = 0,
  parameter logic [AW-1:0]   A_REASON  = 1,
  parameter logic [AW-1:0]   A_SEQ     = 2,
  parameter logic [AW-1:0]   A_CFG     = 3,
  parameter logic [AW-1:0]   A_CSTAT   = 4,
  parameter logic [2:0]      SEQ_DONE  = 3'd4,
  parameter logic [2:0]      PH_STATUS = 3'd3,
  parameter logic [7:0]      CFG_INIT  = 8'h07,
  parameter int              RRD_BIT   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          ev_soft_rst,
  input  logic          ev_cmd_done,
  input  logic [7:0]    ev_cmd_status,
  input  logic          ev_dma_done,
  input  logic          ev_bus_reset,
  input  logic          ev_sel_off,
  input  logic          ev_sel_on,
  output logic          irq,
  output logic [7:0]    stat_o,
  output logic [7:0]    reason_o,
  output logic [2:0]    seq_o
);
  localparam int         ST_INT  = 7;
  localparam int         ST_TC   = 4;
  localparam logic [7:0] RS_RST  = 8'h80;
  localparam logic [7:0] RS_BSVC = 8'h10;
  localparam logic [7:0] ST_DONE = {1'b1, 2'b00, 1'b1, 1'b0, PH_STATUS};

  logic [7:0] stat_q, reason_q, cfg_q, cstat_q, hbyte_q;
  logic [2:0] seq_q;
  logic       hold_q, irq_q;

  logic [7:0] n_stat, n_reason, n_cfg, n_cstat, n_hbyte;
  logic [2:0] n_seq;
  logic       n_hold;

  wire ack = reg_rd && (reg_addr == A_REASON);

  always_comb begin
    n_stat   = stat_q;
    n_reason = reason_q;
    n_seq    = seq_q;
    n_cfg    = cfg_q;
    n_cstat  = cstat_q;
    n_hold   = hold_q;
    n_hbyte  = hbyte_q;

    if (reg_wr && reg_addr == A_CFG) n_cfg = reg_wdata;

    if (ack) begin
      n_reason       = 8'h00;
      n_stat[ST_TC]  = 1'b0;
      n_stat[ST_INT] = 1'b0;
      n_seq          = SEQ_DONE;
      if (hold_q) begin
        n_stat   = ST_DONE;
        n_reason = RS_BSVC;
        n_seq    = 3'd0;
        n_cstat  = hbyte_q;
        n_hold   = 1'b0;
      end
    end

    if (ev_cmd_done) begin
      if (n_stat[ST_INT]) begin
        n_hold  = 1'b1;
        n_hbyte = ev_cmd_status;
      end else begin
        n_stat   = ST_DONE;
        n_reason = RS_BSVC;
        n_seq    = 3'd0;
        n_cstat  = ev_cmd_status;
      end
    end

    if (ev_dma_done) begin
      n_stat[ST_TC]  = 1'b1;
      n_stat[ST_INT] = 1'b1;
      n_reason       = RS_BSVC;
      n_seq          = 3'd0;
    end

    if (ev_bus_reset) begin
      n_reason = RS_RST;
      if (!cfg_q[RRD_BIT]) n_stat[ST_INT] = 1'b1;
    end

    if (ev_sel_off) begin
      n_reason       = 8'h00;
      n_stat[ST_INT] = 1'b1;
    end

    if (ev_sel_on) n_reason = 8'h00;

    if (ev_soft_rst) begin
      n_stat   = 8'h00;
      n_reason = 8'h00;
      n_seq    = 3'd0;
      n_cfg    = CFG_INIT;
      n_cstat  = 8'h00;
      n_hold   = 1'b0;
      n_hbyte  = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= 8'h00;
      reason_q <= 8'h00;
      seq_q    <= 3'd0;
      cfg_q    <= CFG_INIT;
      cstat_q  <= 8'h00;
      hold_q   <= 1'b0;
      hbyte_q  <= 8'h00;
      irq_q    <= 1'b0;
    end else begin
      stat_q   <= n_stat;
      reason_q <= n_reason;
      seq_q    <= n_seq;
      cfg_q    <= n_cfg;
      cstat_q  <= n_cstat;
      hold_q   <= n_hold;
      hbyte_q  <= n_hbyte;
      irq_q    <= n_stat[ST_INT];
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:   reg_rdata = stat_q;
      A_REASON: reg_rdata = reason_q;
      A_SEQ:    reg_rdata = {5'd0, seq_q};
      A_CFG:    reg_rdata = cfg_q;
      A_CSTAT:  reg_rdata = cstat_q;
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign irq      = irq_q;
  assign stat_o   = stat_q;
  assign reason_o = reason_q;
  assign seq_o    = seq_q;
endmodule

module scsi_int_status_chk #(
  parameter int            AW       = 3,
  parameter logic [AW-1:0] A_REASON = 1,
  parameter logic [2:0]    SEQ_DONE = 3'd4,
  parameter logic [7:0]    CFG_INIT = 8'h07,
  parameter int            RRD_BIT  = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          ev_soft_rst,
  input logic          ev_cmd_done,
  input logic          ev_dma_done,
  input logic          ev_bus_reset,
  input logic          ev_sel_off,
  input logic          ev_sel_on,
  input logic          irq,
  input logic [7:0]    stat_o,
  input logic [7:0]    reason_o,
  input logic [2:0]    seq_o,
  input logic [7:0]    cfg_q,
  input logic          hold_q
);
  wire ack     = reg_rd && (reg_addr == A_REASON);
  wire others  = ev_soft_rst | ev_dma_done | ev_bus_reset | ev_sel_off | ev_sel_on;
  wire any_ev  = others | ev_cmd_done;

  // R2
  a_r2_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !any_ev && !hold_q) |=> (!irq && reason_o == 8'h00 && seq_o == SEQ_DONE && !stat_o[4]));

  // R3
  a_r3_post_done: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_done && !others && !ack && !stat_o[7]) |=> (irq && stat_o[4] && reason_o == 8'h10 && seq_o == 3'd0));

  // R4
  a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_done && !others && !ack && stat_o[7]) |=> ($stable(stat_o) && $stable(reason_o) && $stable(seq_o) && hold_q));

  // R4
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hold_q && !any_ev) |=> (irq && reason_o == 8'h10 && !hold_q));

  // R6
  a_r6_report_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_reset && !ev_cmd_done && !ev_dma_done && !ev_sel_off && !ev_soft_rst && !ack && !irq && cfg_q[RRD_BIT])
      |=> (!irq && reason_o == 8'h80));

  // R9
  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ev_soft_rst |=> (!irq && stat_o == 8'h00 && reason_o == 8'h00 && cfg_q == CFG_INIT && !hold_q));

  // R10
  a_r10_cfg_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && reg_addr == 3'd3) && !ev_soft_rst) |=> $stable(cfg_q));
endmodule

bind scsi_int_status scsi_int_status_chk #(
  .AW(AW), .A_REASON(A_REASON), .SEQ_DONE(SEQ_DONE), .CFG_INIT(CFG_INIT), .RRD_BIT(RRD_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ev_soft_rst(ev_soft_rst), .ev_cmd_done(ev_cmd_done), .ev_dma_done(ev_dma_done),
  .ev_bus_reset(ev_bus_reset), .ev_sel_off(ev_sel_off), .ev_sel_on(ev_sel_on),
  .irq(irq), .stat_o(stat_o), .reason_o(reason_o), .seq_o(seq_o),
  .cfg_q(cfg_q), .hold_q(hold_q)
);

// File: tb/scsi_int_status_bench.sv
module scsi_int_status_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_rd, reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       ev_soft_rst, ev_cmd_done, ev_dma_done, ev_bus_reset, ev_sel_off, ev_sel_on;
  logic [7:0] ev_cmd_status;
  logic       irq;
  logic [7:0] stat_o, reason_o;
  logic [2:0] seq_o;

  always #(CLK_P/2) clk = ~clk;

  scsi_int_status u_scsi_int_status (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_soft_rst(ev_soft_rst),
    .ev_cmd_done(ev_cmd_done), .ev_cmd_status(ev_cmd_status), .ev_dma_done(ev_dma_done),
    .ev_bus_reset(ev_bus_reset), .ev_sel_off(ev_sel_off), .ev_sel_on(ev_sel_on),
    .irq(irq), .stat_o(stat_o), .reason_o(reason_o), .seq_o(seq_o)
  );

  typedef struct {
    int         due;
    int         fld;
    logic [7:0] val;
    string      req;
  } exp_t;

  localparam int F_IRQ = 0, F_STAT = 1, F_REASON = 2, F_SEQ = 3, F_RDATA = 4;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   fin = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pick(int f);
    case (f)
      F_IRQ:    return {7'd0, irq};
      F_STAT:   return stat_o;
      F_REASON: return reason_o;
      F_SEQ:    return {5'd0, seq_o};
      default:  return reg_rdata;
    endcase
  endfunction

  always @(negedge clk) begin
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].due == cyc) begin
        logic [7:0] act;
        act = pick(q[i].fld);
        total++;
        if (act !== q[i].val) begin
          bad++;
          $display("FAIL %s field=%0d cycle=%0d actual=%02h expected=%02h",
                   q[i].req, q[i].fld, cyc, act, q[i].val);
        end
      end
    end
    for (int i = q.size() - 1; i >= 0; i--)
      if (q[i].due <= cyc) q.delete(i);
  end

  task automatic expect_at(int dly, int f, logic [7:0] v, string r);
    exp_t e;
    e.due = cyc + dly; e.fld = f; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic start_cycle();
    @(posedge clk);
    #1;
    reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    ev_soft_rst = 0; ev_cmd_done = 0; ev_cmd_status = 0; ev_dma_done = 0;
    ev_bus_reset = 0; ev_sel_off = 0; ev_sel_on = 0;
  endtask

  task automatic rd(logic [2:0] a);
    reg_rd = 1; reg_addr = a;
  endtask

  initial begin
    reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    ev_soft_rst = 0; ev_cmd_done = 0; ev_cmd_status = 0; ev_dma_done = 0;
    ev_bus_reset = 0; ev_sel_off = 0; ev_sel_on = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    start_cycle();
    expect_at(0, F_IRQ, 8'h00, "R1"); expect_at(0, F_STAT, 8'h00, "R1");
    expect_at(0, F_REASON, 8'h00, "R1"); expect_at(0, F_SEQ, 8'h00, "R1");
    rd(3); expect_at(0, F_RDATA, 8'h07, "R1");

    // R10 writes
    start_cycle(); reg_wr = 1; reg_addr = 3; reg_wdata = 8'h00;
    start_cycle(); reg_wr = 1; reg_addr = 1; reg_wdata = 8'hFF;
    start_cycle(); rd(3); expect_at(0, F_RDATA, 8'h00, "R10");
    expect_at(0, F_REASON, 8'h00, "R10");

    // R3 completion posted
    start_cycle(); ev_cmd_done = 1; ev_cmd_status = 8'h02;
    expect_at(1, F_STAT, 8'h93, "R3"); expect_at(1, F_REASON, 8'h10, "R3");
    expect_at(1, F_SEQ, 8'h00, "R3"); expect_at(1, F_IRQ, 8'h01, "R3");

    // R4 completion held
    start_cycle(); ev_cmd_done = 1; ev_cmd_status = 8'h08;
    expect_at(1, F_STAT, 8'h93, "R4"); expect_at(1, F_REASON, 8'h10, "R4");
    expect_at(1, F_IRQ, 8'h01, "R4");
    start_cycle(); rd(4); expect_at(0, F_RDATA, 8'h02, "R4");

    // R2 ack releases held completion (R4)
    start_cycle(); rd(1); expect_at(0, F_RDATA, 8'h10, "R2");
    expect_at(1, F_STAT, 8'h93, "R4"); expect_at(1, F_REASON, 8'h10, "R4");
    expect_at(1, F_IRQ, 8'h01, "R4"); expect_at(1, F_SEQ, 8'h00, "R4");
    start_cycle(); rd(4); expect_at(0, F_RDATA, 8'h08, "R4");

    // R2 plain acknowledge
    start_cycle(); rd(1); expect_at(0, F_RDATA, 8'h10, "R2");
    expect_at(1, F_REASON, 8'h00, "R2"); expect_at(1, F_STAT, 8'h03, "R2");
    expect_at(1, F_SEQ, 8'h04, "R2"); expect_at(1, F_IRQ, 8'h00, "R2");

    // R8 DMA done
    start_cycle(); ev_dma_done = 1;
    expect_at(1, F_STAT, 8'h93, "R8"); expect_at(1, F_REASON, 8'h10, "R8");
    expect_at(1, F_SEQ, 8'h00, "R8"); expect_at(1, F_IRQ, 8'h01, "R8");

    // R5 ack and bus reset together
    start_cycle(); rd(1); ev_bus_reset = 1; expect_at(0, F_RDATA, 8'h10, "R5");
    expect_at(1, F_REASON, 8'h80, "R5"); expect_at(1, F_IRQ, 8'h01, "R5");
    expect_at(1, F_STAT, 8'h83, "R5"); expect_at(1, F_SEQ, 8'h04, "R5");

    // R6 reset report suppressed
    start_cycle(); rd(1); expect_at(0, F_RDATA, 8'h80, "R6");
    expect_at(1, F_IRQ, 8'h00, "R6"); expect_at(1, F_STAT, 8'h03, "R6");
    start_cycle(); reg_wr = 1; reg_addr = 3; reg_wdata = 8'h40;
    start_cycle(); ev_bus_reset = 1;
    expect_at(1, F_REASON, 8'h80, "R6"); expect_at(1, F_IRQ, 8'h00, "R6");
    expect_at(1, F_STAT, 8'h03, "R6");

    // R7 selection enable / disable
    start_cycle(); ev_sel_on = 1;
    expect_at(1, F_REASON, 8'h00, "R7"); expect_at(1, F_IRQ, 8'h00, "R7");
    start_cycle(); ev_sel_off = 1;
    expect_at(1, F_IRQ, 8'h01, "R7"); expect_at(1, F_STAT, 8'h83, "R7");
    expect_at(1, F_REASON, 8'h00, "R7");
    start_cycle(); rd(1); expect_at(0, F_RDATA, 8'h00, "R2");
    expect_at(1, F_IRQ, 8'h00, "R2");

    // R9 soft reset drops held completion
    start_cycle(); ev_dma_done = 1; expect_at(1, F_IRQ, 8'h01, "R9");
    start_cycle(); ev_cmd_done = 1; ev_cmd_status = 8'h22;
    start_cycle(); ev_soft_rst = 1;
    expect_at(1, F_IRQ, 8'h00, "R9"); expect_at(1, F_STAT, 8'h00, "R9");
    expect_at(1, F_REASON, 8'h00, "R9"); expect_at(1, F_SEQ, 8'h00, "R9");
    start_cycle(); rd(3); expect_at(0, F_RDATA, 8'h07, "R9");
    start_cycle(); rd(1); expect_at(0, F_RDATA, 8'h00, "R9");
    expect_at(1, F_IRQ, 8'h00, "R9"); expect_at(1, F_REASON, 8'h00, "R9");
    start_cycle(); rd(4); expect_at(0, F_RDATA, 8'h00, "R9");

    repeat (3) start_cycle();
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!fin) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule